// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block forms the product of two 32-bit binary floating-point operands laid out as one sign bit, eight exponent bits and twenty-three fraction bits. Each operand's significand gets its hidden leading one back. The two 24-bit significands are multiplied. The exponents are added and one bias is taken away. The raw product is normalized and rounded to nearest with ties to even. A second normalization follows when the rounding carries out. The result sign is the exclusive OR of the operand signs.

Reserved encodings are decoded on both inputs. An all-zero exponent counts as zero, so denormal operands are flushed. The all-ones exponent stands for infinity when the fraction is zero and for NaN when it is not. A result exponent outside the normal range saturates to signed infinity on overflow or to signed zero on underflow. There is no handshake. New operands may be applied on every clock, and the registered result appears one clock later.

Top module: `fp_mul`

## Requirements
- R1: While reset is asserted the result output is 0x00000000. After reset, the product of the operands sampled at one rising edge is presented on the result from that edge until the next one, so the latency is one clock.
- R2: For non-NaN results the sign bit (bit 31) is the XOR of the two operand sign bits. This includes infinities and zeros.
- R3: For normal operands the biased result exponent (bits 30:23) equals the sum of the operand exponents minus 127, plus any normalization increments. An exact result such as 1.5 times 2.0 is returned exactly as 0x40400000.
- R4: When the significand product is 2.0 or greater it is shifted right by one and the exponent is incremented. For example, 1.5 times 1.5 gives 0x40100000.
- R5: Discarded product bits are rounded to nearest using a guard bit and a sticky bit. An exact tie goes to the even fraction. 0x3F800001 times 0x3FC00000 gives 0x3FC00002, and 0x3F800003 times 0x3FC00000 gives 0x3FC00004.
- R6: When rounding carries the significand up to 2.0, the fraction becomes zero and the exponent is incremented. 0x3F800001 times 0x3FFFFFFE gives 0x40000000.
- R7: A final biased exponent of 255 or more yields signed infinity (exponent all ones, fraction zero). An exponent of 254 is still returned as a finite value.
- R8: A final biased exponent of 0 or less yields signed zero. The output never carries a zero exponent with a nonzero fraction.
- R9: An operand with exponent field 0 counts as zero, whatever its fraction. Zero times any finite value gives signed zero.
- R10: Infinity times a nonzero, non-NaN operand gives signed infinity.
- R11: A NaN operand, or zero times infinity, gives the quiet NaN 0x7FC00000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| p_o | output | 32 | Registered product |

## Verification
The checker watches several properties every cycle, each judged against the operands sampled at the previous edge:
- the sign of every non-NaN result;
- the canonical quiet NaN for NaN operands and for zero times infinity;
- signed zero when a zero meets a finite value;
- signed infinity when an infinity meets a nonzero value;
- the absence of denormal outputs.

The arithmetic path can only be shown by the bench's chosen operand pairs. This covers exponent bias removal, the normalizing shift, round-to-nearest-even ties in both directions, the carry-out renormalization, and the exact overflow and underflow exponent boundaries.

// File: rtl/fp_mul.sv
module fp_mul #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [EXP_W+FRAC_W:0]     a_i,
  input  logic [EXP_W+FRAC_W:0]     b_i,
  output logic [EXP_W+FRAC_W:0]     p_o
);
  localparam int W      = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int EW     = EXP_W + 2;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX   = (1 << EXP_W) - 1;
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [EXP_W-1:0]  ea, eb;
  logic [FRAC_W-1:0] fa, fb;
  logic              sgn;
  assign ea  = a_i[W-2:FRAC_W];
  assign eb  = b_i[W-2:FRAC_W];
  assign fa  = a_i[FRAC_W-1:0];
  assign fb  = b_i[FRAC_W-1:0];
  assign sgn = a_i[W-1] ^ b_i[W-1];

  logic a_zero, b_zero, a_inf, b_inf, a_nan, b_nan;
  assign a_zero = (ea == '0);
  assign b_zero = (eb == '0);
  assign a_inf  = (ea == EXP_W'(EMAX)) && (fa == '0);
  assign b_inf  = (eb == EXP_W'(EMAX)) && (fb == '0);
  assign a_nan  = (ea == EXP_W'(EMAX)) && (fa != '0);
  assign b_nan  = (eb == EXP_W'(EMAX)) && (fb != '0);

  logic [PROD_W-1:0] prod;
  assign prod = PROD_W'({1'b1, fa}) * PROD_W'({1'b1, fb});

  logic             hi, guard, sticky, rnd_up, carry;
  logic [SIG_W-1:0] sig;
  logic [SIG_W:0]   sig_r;
  assign hi     = prod[PROD_W-1];
  assign sig    = hi ? prod[PROD_W-1 -: SIG_W] : prod[PROD_W-2 -: SIG_W];
  assign guard  = hi ? prod[FRAC_W] : prod[FRAC_W-1];
  assign sticky = hi ? |prod[FRAC_W-1:0] : |prod[FRAC_W-2:0];
  assign rnd_up = guard & (sticky | sig[0]);
  assign sig_r  = {1'b0, sig} + (SIG_W+1)'(rnd_up);
  assign carry  = sig_r[SIG_W];

  logic signed [EW-1:0] e_res;
  assign e_res = $signed(EW'(ea) + EW'(eb) - EW'(BIAS) + EW'(hi) + EW'(carry));

  logic [W-1:0] res;
  always_comb begin
    if (a_nan || b_nan || (a_zero && b_inf) || (a_inf && b_zero))
      res = QNAN;
    else if (a_inf || b_inf)
      res = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (a_zero || b_zero)
      res = {sgn, {(W-1){1'b0}}};
    else if (e_res >= $signed(EW'(EMAX)))
      res = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (e_res <= $signed(EW'(0)))
      res = {sgn, {(W-1){1'b0}}};
    else
      res = {sgn, e_res[EXP_W-1:0], carry ? {FRAC_W{1'b0}} : sig_r[FRAC_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) p_o <= '0;
    else        p_o <= res;
  end
endmodule

// File: rtl/fp_mul_chk.sv
module fp_mul_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [EXP_W+FRAC_W:0] a_i,
  input logic [EXP_W+FRAC_W:0] b_i,
  input logic [EXP_W+FRAC_W:0] p_o
);
  localparam int W    = 1 + EXP_W + FRAC_W;
  localparam int EMAX = (1 << EXP_W) - 1;
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  logic az, bz, ai, bi, an, bn;
  assign az = (a_i[W-2:FRAC_W] == '0);
  assign bz = (b_i[W-2:FRAC_W] == '0);
  assign ai = (a_i[W-2:FRAC_W] == EXP_W'(EMAX)) && (a_i[FRAC_W-1:0] == '0);
  assign bi = (b_i[W-2:FRAC_W] == EXP_W'(EMAX)) && (b_i[FRAC_W-1:0] == '0);
  assign an = (a_i[W-2:FRAC_W] == EXP_W'(EMAX)) && (a_i[FRAC_W-1:0] != '0);
  assign bn = (b_i[W-2:FRAC_W] == EXP_W'(EMAX)) && (b_i[FRAC_W-1:0] != '0);

  logic in_nan, in_inf, in_zero;
  assign in_nan  = an || bn || (az && bi) || (ai && bz);
  assign in_inf  = (ai || bi) && !in_nan;
  assign in_zero = (az || bz) && !in_nan;

  p_sign_xor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(in_nan) |-> p_o[W-1] == ($past(a_i[W-1]) ^ $past(b_i[W-1])));

  p_no_denorm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    p_o[W-2:FRAC_W] == '0 |-> p_o[FRAC_W-1:0] == '0);

  p_zero_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(in_zero) |-> p_o[W-2:0] == '0);

  p_inf_prop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(in_inf) |-> p_o[W-2:0] == INF_MAG);

  p_qnan_r11: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(in_nan) |-> p_o == QNAN);

  always_comb begin
    if (!rst_n) p_reset_zero_r1: assert (p_o == '0);
  end
endmodule

bind fp_mul fp_mul_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .p_o(p_o));

// File: tb/fp_mul_test.sv
`timescale 1ns/1ps
module fp_mul_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [31:0] p_o;
  int checks = 0, errors = 0;

  fp_mul uut (.clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .p_o(p_o));

  always #2.5 clk = ~clk;

  localparam int NV = 24;
  // {tag, a, b, expected}
  localparam logic [99:0] VEC [NV] = '{
    {4'd3,  32'h3FC00000, 32'h40000000, 32'h40400000}, // R3 1.5*2
    {4'd2,  32'hBF400000, 32'h40800000, 32'hC0400000}, // R2 -0.75*4
    {4'd2,  32'hC0A00000, 32'hBF000000, 32'h40200000}, // R2 -5*-0.5
    {4'd4,  32'h3FC00000, 32'h3FC00000, 32'h40100000}, // R4 1.5*1.5
    {4'd4,  32'h3FFFFFFF, 32'h3FFFFFFF, 32'h407FFFFE}, // R4 near 4
    {4'd5,  32'h3F800001, 32'h3FC00000, 32'h3FC00002}, // R5 tie, odd -> up
    {4'd5,  32'h3F800003, 32'h3FC00000, 32'h3FC00004}, // R5 tie, even stays
    {4'd6,  32'h3F800001, 32'h3FFFFFFE, 32'h40000000}, // R6 round carry
    {4'd7,  32'h7F000000, 32'h7F000000, 32'h7F800000}, // R7 far overflow
    {4'd7,  32'h5F800000, 32'h5F800000, 32'h7F800000}, // R7 exp exactly 255
    {4'd7,  32'hDF800000, 32'h5F800000, 32'hFF800000}, // R7 negative
    {4'd7,  32'h5F000000, 32'h5F800000, 32'h7F000000}, // R7 exp 254 finite
    {4'd8,  32'h20000000, 32'h20000000, 32'h00800000}, // R8 exp 1 kept
    {4'd8,  32'h20000000, 32'h1F800000, 32'h00000000}, // R8 exp 0 -> zero
    {4'd8,  32'h80800000, 32'h00800000, 32'h80000000}, // R8 signed zero
    {4'd9,  32'h00000000, 32'h40400000, 32'h00000000}, // R9 zero
    {4'd9,  32'h80000000, 32'h40400000, 32'h80000000}, // R9 negative zero
    {4'd9,  32'h00000001, 32'h3F800000, 32'h00000000}, // R9 denormal flush
    {4'd10, 32'h7F800000, 32'hC0000000, 32'hFF800000}, // R10 inf*-2
    {4'd10, 32'h7F800000, 32'h7F800000, 32'h7F800000}, // R10 inf*inf
    {4'd11, 32'h00000000, 32'h7F800000, 32'h7FC00000}, // R11 zero*inf
    {4'd11, 32'h7F800001, 32'h3F800000, 32'h7FC00000}, // R11 nan in
    {4'd11, 32'hFFC00000, 32'h00000000, 32'h7FC00000}, // R11 nan*zero
    {4'd11, 32'h00000001, 32'hFF800000, 32'h7FC00000}  // R11 denormal*inf
  };

  task automatic check(input int tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    a_i = a;
    b_i = b;
  endtask

  initial begin
    // R1: reset holds output at zero even with operands present
    a_i = 32'h3FC00000; b_i = 32'h40000000;
    repeat (3) @(negedge clk);
    check(1, p_o, 32'h00000000);
    rst_n = 1'b1;
    @(negedge clk);
    check(1, p_o, 32'h40400000);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][95:64], VEC[i][63:32]);
      @(negedge clk);
      check(int'(VEC[i][99:96]), p_o, VEC[i][31:0]);
    end

    // R1: one-clock latency, old result held until the next edge
    apply(32'h40000000, 32'h40000000);
    @(negedge clk);
    check(1, p_o, 32'h40800000);
    a_i = 32'h3FC00000; b_i = 32'h3FC00000;
    #1;
    check(1, p_o, 32'h40800000);
    @(negedge clk);
    check(4, p_o, 32'h40100000);

    // R2: back-to-back operands, sign on infinity and zero
    apply(32'hFF800000, 32'hBF800000);
    apply(32'h80000000, 32'hC0000000);
    check(2, p_o, 32'h7F800000);
    @(negedge clk);
    check(2, p_o, 32'h00000000);

    // R1: reset mid-run clears output
    rst_n = 1'b0;
    #1;
    check(1, p_o, 32'h00000000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule